// File: doc/BRIEF.md
# Glitch-Free Clock Stop Gating

This block sits between a set of free-running clocks and their output drivers. It stops and restarts each output on two kinds of request: a power-down request, and a stop command that comes from a control register. An output never loses part of a pulse. Single-ended outputs stop at logic low. Differential outputs are modelled as a true leg and a complement leg, each with its own tri-state enable. A differential output parks with its true leg driven high, or with both legs released, as its mode bits select.

Each gated clock enters the block as a level, sampled on a fast system clock, and leaves it as a registered level. Every output has its own gate. That gate changes its run/stop decision only during the phase of its own clock in which the change cannot cut a pulse short. A single qualifier, shared by all outputs, turns the raw power-down request into a recognised power-down. It does so only after the request has been seen high on consecutive rising edges of a reference clock, normally the processor complement clock.

Top module: `clk_stop_gate`

## Requirements
- R1: While reset is applied, every single-ended output is low and every differential enable (true and complement) is 0.
- R2: Power-down is recognised only after `pd_req` is sampled high on two consecutive rising edges of `pd_ref_clk`. A request seen on a single rising edge has no effect. A rising edge with `pd_req` low withdraws recognition.
- R3: While power-down is recognised, every single-ended output is held low, starting at its next falling edge.
- R4: After power-down is recognised, a running differential output stops at the next rising edge of its true leg, well within 4 of its own periods.
- R5: A differential output parked by power-down with `dif_pd_hiz` = 0 drives true = 1, true enable = 1 and complement enable = 0. With `dif_pd_hiz` = 1 both enables are 0.
- R6: `stop_n` = 0 stops every output whose stoppable bit is 1. `stop_n` = 1 restarts those outputs.
- R7: An output whose stoppable bit is 0 keeps toggling while `stop_n` = 0.
- R8: A differential output stopped by `stop_n` parks with true driven high and the complement released when `dif_stop_hiz` = 0. When `dif_stop_hiz` = 1, both legs are released.
- R9: Once power-down is withdrawn, a differential output that it had tri-stated drives true = 1 with true enable = 1 before it resumes toggling.
- R10: An enable bit of 0 overrides every other condition. A single-ended output is held low. A differential output has both leg enables at 0.
- R11: Gating never shortens a pulse. A single-ended high phase passes whole or not at all. A differential true leg stays high across every stop and every restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all clock levels |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pd_req | input | 1 | Raw power-down request |
| pd_ref_clk | input | 1 | Level of the reference clock that qualifies power-down |
| stop_n | input | 1 | Stop command, 0 = stop the stoppable outputs |
| se_clk_in | input | NUM_SE | Free-running single-ended clock levels |
| se_en | input | NUM_SE | Per-output enable for single-ended outputs |
| se_stoppable | input | NUM_SE | 1 = output obeys the stop command |
| se_clk_out | output | NUM_SE | Gated single-ended clocks |
| dif_clk_in | input | NUM_DIF | Free-running differential clock levels (true phase) |
| dif_en | input | NUM_DIF | Per-output enable for differential outputs |
| dif_stoppable | input | NUM_DIF | 1 = output obeys the stop command |
| dif_pd_hiz | input | NUM_DIF | Power-down park mode, 1 = both legs released |
| dif_stop_hiz | input | NUM_DIF | Stop park mode, 1 = both legs released |
| dif_out_t | output | NUM_DIF | True leg value |
| dif_out_c | output | NUM_DIF | Complement leg value |
| dif_oe_t | output | NUM_DIF | True leg drive enable |
| dif_oe_c | output | NUM_DIF | Complement leg drive enable |

## Verification
While a gate runs, each output is the input level delayed by one register. A stop decision made on a given sample therefore shows up on the output on the next sample. Power-down is recognised one cycle after the second qualifying reference rising sample. An output then parks on the first sample of its deciding phase that follows: low phase for single-ended, high phase for differential. The core comes out of reset three clock edges after `rst_n` rises. The bench model counts those same registers, updates on the rising clock edge and is compared with every output on the falling edge of each cycle. Directed checks on park states, free-running outputs and overrides are placed only after windows longer than the slowest clock period involved, so that they never sample while a transition is still pending.

// File: rtl/clk_stop_pkg.sv
`timescale 1ns/1ps
package clk_stop_pkg;
  // Drive state of one differential output for the next sample.
  typedef enum logic [1:0] {
    DRV_RUN       = 2'd0,
    DRV_PARK_HIGH = 2'd1,
    DRV_PARK_HIZ  = 2'd2
  } diff_drive_e;
endpackage

// File: rtl/clk_stop_pd_qual.sv
`timescale 1ns/1ps
module clk_stop_pd_qual #(
  parameter int PD_SAMPLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_lvl,
  input  logic pd_req,
  output logic pd_on
);
  localparam int CW = $clog2(PD_SAMPLES + 1);
  localparam logic [CW-1:0] CMAX = CW'(PD_SAMPLES);

  logic          ref_q;
  logic          rise;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    rise  = ref_lvl & ~ref_q;
    cnt_d = cnt_q;
    if (rise) begin
      if (!pd_req)            cnt_d = '0;
      else if (cnt_q != CMAX) cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      ref_q <= ref_lvl;
      cnt_q <= cnt_d;
    end
  end

  assign pd_on = (cnt_q == CMAX);

  AST_PD_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_on) |-> $past(pd_req && rise)); // R2
endmodule

// File: rtl/clk_stop_se_gate.sv
`timescale 1ns/1ps
module clk_stop_se_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_lvl,
  input  logic en,
  input  logic stoppable,
  input  logic stop_cmd,
  input  logic pd_on,
  output logic out_q
);
  logic want, run_q, run_d, out_d;

  always_comb begin
    want  = en & ~pd_on & ~(stop_cmd & stoppable);
    // decision may only move while the clock sits low
    run_d = clk_lvl ? run_q : want;
    out_d = clk_lvl & run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      run_q <= run_d;
      out_q <= out_d;
    end
  end

  AST_SE_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q && clk_lvl) |=> out_q); // R11
  AST_SE_RISE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> !$past(clk_lvl, 2)); // R11
endmodule

// File: rtl/clk_stop_dif_gate.sv
`timescale 1ns/1ps
module clk_stop_dif_gate
  import clk_stop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clk_lvl,
  input  logic en,
  input  logic stoppable,
  input  logic stop_cmd,
  input  logic pd_on,
  input  logic pd_hiz,
  input  logic stop_hiz,
  output logic t_q,
  output logic c_q,
  output logic t_oe_q,
  output logic c_oe_q
);
  logic        want, park_hiz, run_q, run_d;
  logic        t_d, c_d, t_oe_d, c_oe_d;
  diff_drive_e mode;

  always_comb begin
    want     = en & ~pd_on & ~(stop_cmd & stoppable);
    park_hiz = ~en | (pd_on & pd_hiz) | (stop_cmd & stoppable & stop_hiz);
    // decision may only move while the complement leg sits low
    run_d    = clk_lvl ? want : run_q;
    if (run_q)         mode = DRV_RUN;
    else if (park_hiz) mode = DRV_PARK_HIZ;
    else               mode = DRV_PARK_HIGH;
    case (mode)
      DRV_RUN:       begin t_d = clk_lvl; c_d = ~clk_lvl; t_oe_d = 1'b1; c_oe_d = 1'b1; end
      DRV_PARK_HIGH: begin t_d = 1'b1;    c_d = 1'b0;     t_oe_d = 1'b1; c_oe_d = 1'b0; end
      default:       begin t_d = 1'b0;    c_d = 1'b0;     t_oe_d = 1'b0; c_oe_d = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      t_q    <= 1'b0;
      c_q    <= 1'b0;
      t_oe_q <= 1'b0;
      c_oe_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      t_q    <= t_d;
      c_q    <= c_d;
      t_oe_q <= t_oe_d;
      c_oe_q <= c_oe_d;
    end
  end

  AST_DIF_PD_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_on && run_q && clk_lvl) |=> !run_q); // R4
  AST_DIF_PARK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> (t_q && t_oe_q)); // R11
  AST_DIF_RESUME_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (t_q && t_oe_q && !c_oe_q)); // R9
endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate #(
  parameter int NUM_SE     = 4,
  parameter int NUM_DIF    = 3,
  parameter int PD_SAMPLES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pd_req,
  input  logic               pd_ref_clk,
  input  logic               stop_n,
  input  logic [NUM_SE-1:0]  se_clk_in,
  input  logic [NUM_SE-1:0]  se_en,
  input  logic [NUM_SE-1:0]  se_stoppable,
  output logic [NUM_SE-1:0]  se_clk_out,
  input  logic [NUM_DIF-1:0] dif_clk_in,
  input  logic [NUM_DIF-1:0] dif_en,
  input  logic [NUM_DIF-1:0] dif_stoppable,
  input  logic [NUM_DIF-1:0] dif_pd_hiz,
  input  logic [NUM_DIF-1:0] dif_stop_hiz,
  output logic [NUM_DIF-1:0] dif_out_t,
  output logic [NUM_DIF-1:0] dif_out_c,
  output logic [NUM_DIF-1:0] dif_oe_t,
  output logic [NUM_DIF-1:0] dif_oe_c
);
  logic rst_s1, rst_i;
  logic pd_on;
  logic stop_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_i  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_i  <= rst_s1;
    end
  end

  assign stop_cmd = ~stop_n;

  clk_stop_pd_qual #(.PD_SAMPLES(PD_SAMPLES)) u_pd (
    .clk(clk), .rst_n(rst_i), .ref_lvl(pd_ref_clk), .pd_req(pd_req), .pd_on(pd_on)
  );

  for (genvar i = 0; i < NUM_SE; i++) begin : g_se
    clk_stop_se_gate u_gate (
      .clk(clk), .rst_n(rst_i), .clk_lvl(se_clk_in[i]), .en(se_en[i]),
      .stoppable(se_stoppable[i]), .stop_cmd(stop_cmd), .pd_on(pd_on),
      .out_q(se_clk_out[i])
    );
  end

  for (genvar j = 0; j < NUM_DIF; j++) begin : g_dif
    clk_stop_dif_gate u_gate (
      .clk(clk), .rst_n(rst_i), .clk_lvl(dif_clk_in[j]), .en(dif_en[j]),
      .stoppable(dif_stoppable[j]), .stop_cmd(stop_cmd), .pd_on(pd_on),
      .pd_hiz(dif_pd_hiz[j]), .stop_hiz(dif_stop_hiz[j]),
      .t_q(dif_out_t[j]), .c_q(dif_out_c[j]), .t_oe_q(dif_oe_t[j]), .c_oe_q(dif_oe_c[j])
    );
  end
endmodule

// File: tb/clk_stop_gate_test.sv
`timescale 1ns/1ps
module clk_stop_gate_test;
  localparam int NSE = 4;
  localparam int NDF = 3;

  logic clk = 1'b0;
  logic rst_n, pd_req, pd_ref_clk, stop_n;
  logic [NSE-1:0] se_clk_in, se_en, se_stoppable, se_clk_out;
  logic [NDF-1:0] dif_clk_in, dif_en, dif_stoppable, dif_pd_hiz, dif_stop_hiz;
  logic [NDF-1:0] dif_out_t, dif_out_c, dif_oe_t, dif_oe_c;

  clk_stop_gate #(.NUM_SE(NSE), .NUM_DIF(NDF), .PD_SAMPLES(2)) uut (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .pd_ref_clk(pd_ref_clk), .stop_n(stop_n),
    .se_clk_in(se_clk_in), .se_en(se_en), .se_stoppable(se_stoppable), .se_clk_out(se_clk_out),
    .dif_clk_in(dif_clk_in), .dif_en(dif_en), .dif_stoppable(dif_stoppable),
    .dif_pd_hiz(dif_pd_hiz), .dif_stop_hiz(dif_stop_hiz),
    .dif_out_t(dif_out_t), .dif_out_c(dif_out_c), .dif_oe_t(dif_oe_t), .dif_oe_c(dif_oe_c)
  );

  always #2.5 clk = ~clk;

  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  bit    started = 1'b0;
  string cur_req = "R11";
  int    cyc = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // free-running clock levels: half period 2..5 (single-ended), 3..5 (differential), 3 (reference)
  always @(negedge clk) begin
    cyc++;
    for (int i = 0; i < NSE; i++) se_clk_in[i] = ((cyc / (i + 2)) % 2) == 1;
    for (int i = 0; i < NDF; i++) dif_clk_in[i] = ((cyc / (i + 3)) % 2) == 1;
    pd_ref_clk = ((cyc / 3) % 2) == 1;
  end

  // behavioural reference model
  int             nrel = 0;
  int             m_cnt;
  bit             m_refq, m_pdon, m_stp, m_w, m_hz;
  bit [NSE-1:0]   m_se_run, m_se_out;
  bit [NDF-1:0]   m_dr, m_t, m_c, m_to, m_co;

  task automatic mreset();
    m_cnt = 0; m_refq = 0; m_se_run = '0; m_se_out = '0;
    m_dr = '0; m_t = '0; m_c = '0; m_to = '0; m_co = '0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      nrel = 0;
      mreset();
    end else begin
      nrel++;
      if (nrel <= 2) mreset();
      else begin
        m_pdon = (m_cnt >= 2);
        m_stp  = !stop_n;
        for (int i = 0; i < NSE; i++) begin
          m_w = se_en[i] && !m_pdon && !(m_stp && se_stoppable[i]);
          m_se_out[i] = se_clk_in[i] && m_se_run[i];
          if (!se_clk_in[i]) m_se_run[i] = m_w;
        end
        for (int i = 0; i < NDF; i++) begin
          m_w  = dif_en[i] && !m_pdon && !(m_stp && dif_stoppable[i]);
          m_hz = !dif_en[i] || (m_pdon && dif_pd_hiz[i]) || (m_stp && dif_stoppable[i] && dif_stop_hiz[i]);
          if (m_dr[i]) begin
            m_t[i] = dif_clk_in[i]; m_c[i] = !dif_clk_in[i]; m_to[i] = 1; m_co[i] = 1;
          end else if (m_hz) begin
            m_t[i] = 0; m_c[i] = 0; m_to[i] = 0; m_co[i] = 0;
          end else begin
            m_t[i] = 1; m_c[i] = 0; m_to[i] = 1; m_co[i] = 0;
          end
          if (dif_clk_in[i]) m_dr[i] = m_w;
        end
        if (pd_ref_clk && !m_refq) m_cnt = pd_req ? ((m_cnt < 2) ? m_cnt + 1 : 2) : 0;
        m_refq = pd_ref_clk;
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk({se_clk_out, dif_out_t, dif_out_c, dif_oe_t, dif_oe_c} ===
          {m_se_out, m_t, m_c, m_to, m_co}, cur_req, "model compare",
          int'({se_clk_out, dif_out_t, dif_out_c, dif_oe_t, dif_oe_c}),
          int'({m_se_out, m_t, m_c, m_to, m_co}));
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(5.0 * 5000);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    bit saw_a, saw_b, saw_c;
    rst_n = 0; pd_req = 0; stop_n = 1;
    se_en = '1; se_stoppable = 4'b0101;
    dif_en = '1; dif_stoppable = 3'b011; dif_pd_hiz = 3'b010; dif_stop_hiz = 3'b001;
    repeat (4) @(negedge clk);
    chk(se_clk_out == '0, "R1", "se outputs in reset", int'(se_clk_out), 0);
    chk({dif_oe_t, dif_oe_c} == '0, "R1", "diff enables in reset", int'({dif_oe_t, dif_oe_c}), 0);
    rst_n = 1;
    started = 1;
    cur_req = "R11";
    repeat (40) @(negedge clk);

    // single qualifying edge only
    cur_req = "R2";
    pd_req = 1;
    repeat (4) @(negedge clk);
    pd_req = 0;
    saw_a = 0;
    repeat (16) begin @(negedge clk); if (se_clk_out[0]) saw_a = 1; end
    chk(saw_a, "R2", "se0 toggles after one-edge request", int'(saw_a), 1);

    // power-down
    cur_req = "R4";
    pd_req = 1;
    repeat (40) @(negedge clk);
    chk(se_clk_out == '0, "R3", "se outputs held low", int'(se_clk_out), 0);
    chk(dif_out_t[0] && dif_oe_t[0] && !dif_oe_c[0], "R5", "dif0 driven park",
        int'({dif_out_t[0], dif_oe_t[0], dif_oe_c[0]}), 3'b110);
    chk(!dif_oe_t[1] && !dif_oe_c[1], "R5", "dif1 released park",
        int'({dif_oe_t[1], dif_oe_c[1]}), 0);
    chk(dif_out_t[2] && dif_oe_t[2] && !dif_oe_c[2], "R4", "dif2 parked high",
        int'({dif_out_t[2], dif_oe_t[2], dif_oe_c[2]}), 3'b110);

    // release
    cur_req = "R9";
    pd_req = 0;
    saw_a = 0;
    repeat (30) begin
      @(negedge clk);
      if (dif_out_t[1] && dif_oe_t[1] && !dif_oe_c[1]) saw_a = 1;
    end
    chk(saw_a, "R9", "dif1 driven high before resume", int'(saw_a), 1);

    // stop command
    cur_req = "R6";
    stop_n = 0;
    saw_a = 0; saw_b = 0; saw_c = 0;
    repeat (40) begin
      @(negedge clk);
      if (se_clk_out[1]) saw_a = 1; else saw_b = 1;
      if (dif_out_t[2] != dif_out_t[2] || !dif_out_t[2]) saw_c = 1;
    end
    chk(saw_a && saw_b, "R7", "se1 free-running", int'({saw_a, saw_b}), 3);
    chk(saw_c, "R7", "dif2 free-running", int'(saw_c), 1);
    chk(!se_clk_out[0] && !se_clk_out[2], "R6", "stoppable se stopped",
        int'({se_clk_out[2], se_clk_out[0]}), 0);
    chk(!dif_oe_t[0] && !dif_oe_c[0], "R8", "dif0 released on stop",
        int'({dif_oe_t[0], dif_oe_c[0]}), 0);
    chk(dif_out_t[1] && dif_oe_t[1] && !dif_oe_c[1], "R8", "dif1 driven park on stop",
        int'({dif_out_t[1], dif_oe_t[1], dif_oe_c[1]}), 3'b110);
    stop_n = 1;
    saw_a = 0; saw_b = 0;
    repeat (30) begin
      @(negedge clk);
      if (se_clk_out[0]) saw_a = 1;
      if (se_clk_out[2]) saw_b = 1;
    end
    chk(saw_a && saw_b, "R6", "stoppable se resumed", int'({saw_b, saw_a}), 3);

    // enable override
    cur_req = "R10";
    se_en[3] = 0; dif_en[2] = 0;
    repeat (12) @(negedge clk);
    repeat (20) begin
      @(negedge clk);
      chk(!se_clk_out[3], "R10", "se3 held low", int'(se_clk_out[3]), 0);
      chk(!dif_oe_t[2] && !dif_oe_c[2], "R10", "dif2 released",
          int'({dif_oe_t[2], dif_oe_c[2]}), 0);
    end
    se_en = '1; dif_en = '1;
    cur_req = "R11";
    repeat (20) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule